// File: doc/BRIEF.md
# Full-Map Coherence Directory Controller

This block is the home-node directory for a small shared-memory system with a fixed number of private caches. For every memory block it keeps a presence vector with one bit per cache and a single-owner flag. The owner flag means that exactly one cache holds the block with write permission. Caches send three kinds of request:

- a read miss;
- a write miss;
- an upgrade, which a cache holding a shared copy sends to obtain write permission.

The controller answers a read miss with data. It answers a write miss with data after it has invalidated every other holder. It answers an upgrade with a grant after the same invalidation. When an owner exists and a read miss arrives, the controller sends that owner a fetch. The owner returns its dirty copy, which is written to memory and then forwarded to the requester.

A write hit on a line whose private bit is already set completes inside the cache and never reaches this block. The backing store is a single-cycle array, and block `i` holds the value `i` after reset. The controller runs one transaction at a time. While a transaction is open, new requests see `req_ready` low and wait.

All three channels are valid/ready streams:

- **Request channel.** A request transfers on a cycle with `req_valid` and `req_ready` both high. The requester must hold its fields stable until that cycle.
- **Outgoing message channel.** Once `msg_valid` rises, `msg_kind`, `msg_dst`, `msg_addr` and `msg_data` stay stable until the cycle in which `msg_ready` is high.
- **Response channel.** A response transfers only in a cycle where `rsp_ready` is high. `rsp_ready` is high only while invalidations or a fetch are outstanding.

Top module: `coh_dir_ctrl`

## Requirements
- R1: After reset every presence vector and owner flag is clear, `req_ready` is 1, `msg_valid` is 0, and memory block `i` holds the value `i`.
- R2: A read miss (`req_op`=0) to a block whose owner flag is clear produces one message of kind DATA (`msg_kind`=0) to the requester carrying the memory contents. The requester is added to the presence vector and the owner flag stays clear.
- R3: A read miss to an owned block first sends one FETCH (`msg_kind`=3) to the owning cache. It then waits for that cache's response, and only after that sends DATA to the requester. Afterwards the owner flag is clear and both caches are present.
- R4: A write miss (`req_op`=1) sends one INV (`msg_kind`=2) to each present cache other than the requester, one per handshake, lowest cache index first. It never sends an INV to the requester.
- R5: A response of kind ACK_DATA (`rsp_kind`=1) writes its payload into the block's memory before any later reply is built. A reply that follows a writeback or fetch therefore carries the returned value.
- R6: When a write miss or upgrade completes, only the requester is present and the owner flag is set. Each owner-flag update leaves exactly one presence bit.
- R7: An upgrade (`req_op`=2) invalidates the other sharers as in R4 and then sends GRANT (`msg_kind`=1) to the requester. If the requester is the only sharer, GRANT is sent without any INV.
- R8: The acknowledgement counter is loaded with the number of caches addressed. Each response (ACK `rsp_kind`=0 or ACK_DATA) decrements it, and a DATA or GRANT reply is only presented once it is zero.
- R9: From the cycle after a request is accepted until the handshake of its DATA or GRANT reply, `req_ready` is 0.
- R10: A presented message keeps `msg_valid` high and its fields unchanged until `msg_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting a request |
| req_src | input | CW (2) | Requesting cache index |
| req_op | input | 2 | 0 read miss, 1 write miss, 2 upgrade |
| req_addr | input | AW (4) | Block index |
| msg_valid | output | 1 | Outgoing message present |
| msg_ready | input | 1 | Network accepts the message |
| msg_kind | output | 2 | 0 DATA, 1 GRANT, 2 INV, 3 FETCH |
| msg_dst | output | CW (2) | Destination cache |
| msg_addr | output | AW (4) | Block index of the message |
| msg_data | output | DW (32) | Block payload for DATA, zero otherwise |
| rsp_valid | input | 1 | Cache response present |
| rsp_ready | output | 1 | Controller waiting for responses |
| rsp_kind | input | 1 | 0 plain acknowledgement, 1 acknowledgement with block data |
| rsp_data | input | DW (32) | Returned block payload |

## Verification
On every cycle the assertions check these properties:

- outgoing messages stay stable while they are stalled;
- `req_ready` drops after a request is accepted;
- no reply appears while acknowledgements are outstanding, and the counter never underflows;
- no INV is addressed to the requester;
- every owner-flag write leaves a single presence bit.

Only the bench's scenarios can show the rest. This covers which caches receive INV or FETCH, the lowest-index-first order, and whether a writeback value reaches the following reply. It also covers whether the directory state left by one transaction produces the correct traffic for the next one. The bench checks all of these against a reference directory that it updates itself.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_UPG = 2'd2
  } req_op_e;

  typedef enum logic [1:0] {
    MK_DATA  = 2'd0,
    MK_GRANT = 2'd1,
    MK_INV   = 2'd2,
    MK_FETCH = 2'd3
  } msg_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_REPLY
  } ctl_state_e;

  localparam logic RK_ACK      = 1'b0;
  localparam logic RK_ACK_DATA = 1'b1;

endpackage

// File: rtl/coh_dir_popcnt.sv
module coh_dir_popcnt #(
  parameter int W  = 4,
  parameter int CNTW = $clog2(W + 1)
) (
  input  logic [W-1:0]    vec,
  output logic [CNTW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < W; i++) begin
      count = count + CNTW'(vec[i]);
    end
  end
endmodule

// File: rtl/coh_dir_lowest.sv
module coh_dir_lowest #(
  parameter int W  = 4,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/coh_dir_entry_store.sv
module coh_dir_entry_store #(
  parameter int NC = 4,
  parameter int NB = 16,
  localparam int AW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [NC-1:0] rd_pres,
  output logic          rd_own,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [NC-1:0] wr_pres,
  input  logic          wr_own
);
  logic [NC-1:0] pres_q [NB];
  logic [NB-1:0] own_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) pres_q[i] <= '0;
      own_q <= '0;
    end else if (wr_en) begin
      pres_q[wr_addr] <= wr_pres;
      own_q[wr_addr]  <= wr_own;
    end
  end

  assign rd_pres = pres_q[rd_addr];
  assign rd_own  = own_q[rd_addr];

  // R6
  owner_single_holder_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_own) |-> ($countones(wr_pres) == 1));

endmodule

// File: rtl/coh_dir_data_mem.sv
module coh_dir_data_mem #(
  parameter int NB = 16,
  parameter int DW = 32,
  localparam int AW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  logic [DW-1:0] mem_q [NB];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) mem_q[i] <= DW'(i);
    end else if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/coh_dir_ack_ctr.sv
module coh_dir_ack_ctr #(
  parameter int NC = 4,
  localparam int CNTW = $clog2(NC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [CNTW-1:0] load_val,
  input  logic            dec,
  output logic            zero
);
  logic [CNTW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load)   cnt_q <= load_val;
    else if (dec)    cnt_q <= cnt_q - CNTW'(1);
  end

  assign zero = (cnt_q == '0);

  // R8
  ack_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (cnt_q != '0));

endmodule

// File: rtl/coh_dir_ctrl.sv
module coh_dir_ctrl
  import coh_dir_pkg::*;
#(
  parameter int NCACHE = 4,
  parameter int NBLK   = 16,
  parameter int DW     = 32,
  localparam int CW    = (NCACHE > 1) ? $clog2(NCACHE) : 1,
  localparam int AW    = $clog2(NBLK),
  localparam int CNTW  = $clog2(NCACHE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [CW-1:0] req_src,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  output logic          msg_valid,
  input  logic          msg_ready,
  output logic [1:0]    msg_kind,
  output logic [CW-1:0] msg_dst,
  output logic [AW-1:0] msg_addr,
  output logic [DW-1:0] msg_data,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic          rsp_kind,
  input  logic [DW-1:0] rsp_data
);

  ctl_state_e      state_q;
  logic [CW-1:0]   cur_src_q;
  req_op_e         cur_op_q;
  logic [AW-1:0]   cur_addr_q;
  logic [NCACHE-1:0] pend_q;

  logic [AW-1:0]     ent_rd_addr;
  logic [NCACHE-1:0] ent_pres;
  logic              ent_own;
  logic              ent_wr;
  logic [NCACHE-1:0] ent_wr_pres;
  logic              ent_wr_own;

  logic [DW-1:0]     mem_rd;
  logic              mem_wr;

  logic [NCACHE-1:0] req_oh;
  logic [NCACHE-1:0] cur_oh;
  logic [NCACHE-1:0] others;
  logic [CNTW-1:0]   others_cnt;
  logic [CW-1:0]     pend_low;
  logic [NCACHE-1:0] pend_low_oh;

  logic req_fire, msg_fire, rsp_fire;
  logic ack_load, ack_zero;
  logic [CNTW-1:0] ack_load_val;

  assign req_oh      = NCACHE'(1) << req_src;
  assign cur_oh      = NCACHE'(1) << cur_src_q;
  assign others      = ent_pres & ~req_oh;
  assign pend_low_oh = NCACHE'(1) << pend_low;

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_ready = (state_q == ST_SEND) || (state_q == ST_WAIT);
  assign req_fire  = req_valid && req_ready;
  assign msg_fire  = msg_valid && msg_ready;
  assign rsp_fire  = rsp_valid && rsp_ready;

  assign ent_rd_addr = (state_q == ST_IDLE) ? req_addr : cur_addr_q;

  coh_dir_entry_store #(.NC(NCACHE), .NB(NBLK)) u_entries (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (ent_rd_addr),
    .rd_pres (ent_pres),
    .rd_own  (ent_own),
    .wr_en   (ent_wr),
    .wr_addr (cur_addr_q),
    .wr_pres (ent_wr_pres),
    .wr_own  (ent_wr_own)
  );

  coh_dir_data_mem #(.NB(NBLK), .DW(DW)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (cur_addr_q),
    .rd_data (mem_rd),
    .wr_en   (mem_wr),
    .wr_addr (cur_addr_q),
    .wr_data (rsp_data)
  );

  coh_dir_popcnt #(.W(NCACHE)) u_pop (
    .vec   (others),
    .count (others_cnt)
  );

  coh_dir_lowest #(.W(NCACHE)) u_low (
    .vec (pend_q),
    .idx (pend_low)
  );

  coh_dir_ack_ctr #(.NC(NCACHE)) u_acks (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ack_load),
    .load_val (ack_load_val),
    .dec      (rsp_fire),
    .zero     (ack_zero)
  );

  // Owner returns its copy on a fetch or writeback
  assign mem_wr = rsp_fire && (rsp_kind == RK_ACK_DATA);

  // Acknowledgement count decided at request acceptance
  always_comb begin
    ack_load     = 1'b0;
    ack_load_val = '0;
    if (req_fire) begin
      if (req_op_e'(req_op) == OP_RD) begin
        ack_load     = ent_own;
        ack_load_val = ent_own ? CNTW'(1) : '0;
      end else begin
        ack_load     = 1'b1;
        ack_load_val = others_cnt;
      end
    end
  end

  // Outgoing message mux
  always_comb begin
    msg_valid = 1'b0;
    msg_kind  = MK_DATA;
    msg_dst   = cur_src_q;
    msg_addr  = cur_addr_q;
    msg_data  = '0;
    case (state_q)
      ST_SEND: begin
        msg_valid = 1'b1;
        msg_kind  = (cur_op_q == OP_RD) ? MK_FETCH : MK_INV;
        msg_dst   = pend_low;
      end
      ST_REPLY: begin
        msg_valid = 1'b1;
        if (cur_op_q == OP_UPG) begin
          msg_kind = MK_GRANT;
        end else begin
          msg_kind = MK_DATA;
          msg_data = mem_rd;
        end
      end
      default: ;
    endcase
  end

  // Entry update on reply handshake
  always_comb begin
    ent_wr      = (state_q == ST_REPLY) && msg_fire;
    ent_wr_pres = cur_oh;
    ent_wr_own  = 1'b1;
    if (cur_op_q == OP_RD) begin
      ent_wr_pres = ent_pres | cur_oh;
      ent_wr_own  = 1'b0;
    end
  end

  // Transaction sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cur_src_q  <= '0;
      cur_op_q   <= OP_RD;
      cur_addr_q <= '0;
      pend_q     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_fire) begin
            cur_src_q  <= req_src;
            cur_op_q   <= req_op_e'(req_op);
            cur_addr_q <= req_addr;
            if (req_op_e'(req_op) == OP_RD) begin
              pend_q  <= ent_own ? ent_pres : '0;
              state_q <= ent_own ? ST_SEND : ST_REPLY;
            end else begin
              pend_q  <= others;
              state_q <= (others != '0) ? ST_SEND : ST_REPLY;
            end
          end
        end
        ST_SEND: begin
          if (msg_fire) begin
            pend_q <= pend_q & ~pend_low_oh;
            if ((pend_q & ~pend_low_oh) == '0) state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (ack_zero) state_q <= ST_REPLY;
        end
        ST_REPLY: begin
          if (msg_fire) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R10
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_kind) &&
                                   $stable(msg_dst) && $stable(msg_data)));

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_ready);

  // R8
  reply_after_acks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && (msg_kind == MK_DATA || msg_kind == MK_GRANT)) |-> ack_zero);

  // R4
  no_self_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_kind == MK_INV) |-> (msg_dst != cur_src_q));

endmodule

// File: tb/tb_coh_dir_ctrl.sv
module tb_coh_dir_ctrl;
  localparam int NC = 4;
  localparam int NB = 16;
  localparam int DW = 32;
  localparam int CW = 2;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [CW-1:0] req_src = '0;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic msg_valid;
  logic msg_ready = 1'b0;
  logic [1:0] msg_kind;
  logic [CW-1:0] msg_dst;
  logic [AW-1:0] msg_addr;
  logic [DW-1:0] msg_data;
  logic rsp_valid = 1'b0;
  logic rsp_ready;
  logic rsp_kind = 1'b0;
  logic [DW-1:0] rsp_data = '0;

  always #10 clk = ~clk;

  coh_dir_ctrl #(.NCACHE(NC), .NBLK(NB), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src),
    .req_op(req_op), .req_addr(req_addr),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
    .msg_dst(msg_dst), .msg_addr(msg_addr), .msg_data(msg_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind),
    .rsp_data(rsp_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit ended = 0;

  logic [NC-1:0] m_pres [NB];
  logic          m_own  [NB];
  logic [DW-1:0] m_mem  [NB];

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int lowest(input logic [NC-1:0] v);
    for (int i = 0; i < NC; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog actual=%0h expected=%0h", cyc, 0);
      finish_run();
    end
  end

  task automatic send_rsp(input logic kind, input logic [DW-1:0] data);
    @(negedge clk);
    rsp_valid = 1'b1;
    rsp_kind  = kind;
    rsp_data  = data;
    while (!rsp_ready) @(negedge clk);
    @(posedge clk);
    #1 rsp_valid = 1'b0;
  endtask

  // One full transaction, checked against the reference directory
  task automatic run_txn(input int src, input int op, input int addr);
    logic [NC-1:0] src_oh;
    logic [NC-1:0] exp_set;
    logic [NC-1:0] seen;
    bit done;
    src_oh  = NC'(1) << src;
    exp_set = (op == 0) ? (m_own[addr] ? m_pres[addr] : '0) : (m_pres[addr] & ~src_oh);
    seen = '0;
    done = 0;

    @(negedge clk);
    req_valid = 1'b1;
    req_src   = CW'(src);
    req_op    = 2'(op);
    req_addr  = AW'(addr);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;

    for (int t = 0; t < 400 && !done; t++) begin
      @(negedge clk);
      chk(req_ready == 1'b0, "R9 busy while open", req_ready, 0);
      if (msg_valid) begin
        logic [1:0] k;
        logic [CW-1:0] d;
        logic [DW-1:0] pl;
        int stall;
        k = msg_kind; d = msg_dst; pl = msg_data;
        stall = $urandom % 3;
        for (int s = 0; s < stall; s++) @(negedge clk);
        chk(msg_valid && msg_kind == k && msg_dst == d && msg_data == pl,
            "R10 held while stalled", {msg_valid, msg_kind, msg_dst}, {1'b1, k, d});
        chk(msg_addr == AW'(addr), "R10 message block", msg_addr, addr);
        msg_ready = 1'b1;
        @(posedge clk);
        #1 msg_ready = 1'b0;
        if (k == 2'd2 || k == 2'd3) begin
          int lw;
          lw = lowest(exp_set & ~seen);
          if (op == 0)
            chk(k == 2'd3, "R3 fetch kind", k, 3);
          else
            chk(k == 2'd2, "R4 inval kind", k, 2);
          chk(lw >= 0 && int'(d) == lw, "R4 target and order", d, lw);
          if (lw >= 0) seen[d] = 1'b1;
          if (m_own[addr] && m_pres[addr][d]) begin
            logic [DW-1:0] nv;
            nv = $urandom;
            m_mem[addr] = nv;
            send_rsp(1'b1, nv);
          end else begin
            send_rsp(1'b0, '0);
          end
        end else begin
          done = 1;
          chk(seen == exp_set, "R8 all acks before reply", seen, exp_set);
          chk(int'(d) == src, "R2 reply destination", d, src);
          if (op == 2) begin
            chk(k == 2'd1, "R7 grant kind", k, 1);
          end else begin
            chk(k == 2'd0, "R2 data kind", k, 0);
            chk(pl == m_mem[addr], (m_own[addr] ? "R5 returned data" : "R2 data value"),
                pl, m_mem[addr]);
          end
        end
      end
    end
    chk(done, "R9 transaction completes", done, 1);
    if (op == 0) begin
      m_pres[addr] = m_pres[addr] | src_oh;
      m_own[addr]  = 1'b0;
    end else begin
      m_pres[addr] = src_oh;
      m_own[addr]  = 1'b1;
    end
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready after reply", req_ready, 1);
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    for (int i = 0; i < NB; i++) begin
      m_pres[i] = '0;
      m_own[i]  = 1'b0;
      m_mem[i]  = DW'(i);
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(msg_valid == 1'b0, "R1 no message after reset", msg_valid, 0);
    chk(rsp_ready == 1'b0, "R1 no response wait after reset", rsp_ready, 0);

    // Directed corner cases
    run_txn(0, 0, 5);   // R1 initial content, R2 fresh read
    run_txn(1, 0, 5);   // R2 second sharer
    run_txn(3, 1, 5);   // R4 two invalidations, lowest first
    run_txn(2, 0, 5);   // R3 fetch from owner, R5 writeback data
    run_txn(3, 2, 5);   // R7 upgrade with one other sharer
    run_txn(1, 1, 5);   // R5 owner writeback on write miss, R6
    run_txn(1, 0, 7);   // R2
    run_txn(1, 2, 7);   // R7 sole sharer, grant without INV
    run_txn(0, 1, 9);   // R6 write miss with no holder
    run_txn(2, 0, 9);   // R3

    // Constrained random traffic
    for (int n = 0; n < 300; n++) begin
      int s, a;
      s = $urandom % NC;
      a = $urandom % 4;
      if (!m_pres[a][s])
        run_txn(s, ($urandom % 2), a);
      else if (!m_own[a])
        run_txn(s, 2, a);
    end
    finish_run();
  end

endmodule